// File: doc/BRIEF.md
# Flash Data-Polling Status Register

This block holds the status byte that a host sees when it reads a parallel NOR flash while an embedded program or erase is in progress. An external sequencer supplies the kind of operation under way, the erase-suspend state and whether the addressed sector is queued for erase. It also pulses single-cycle events when a program starts, an erase starts, the sector-erase accept window closes, an erase is suspended or resumed, and an operation finishes. The block keeps the polling bits up to date from these inputs.

On every read strobe the block applies the toggle rules that fit the current operation. It registers either the new status byte or a flag that tells the bus side to return array data. A host can therefore tell program from erase by which bits change between two reads, and can tell a suspended erase by bit 2 changing while bit 6 stays still. Command decoding and the timing of operations are handled by the sequencer outside this block.

Top module: `flash_poll_status`

## Requirements
- R1: After reset the status byte is 0x00, `rd_data` reads 0x00 and `rd_array` reads 1.
- R2: A `prog_start` pulse sets status bit 7 to the complement of `prog_data[7]`.
- R3: An `erase_start` pulse clears bits 7 and 3. A `resume_evt` pulse clears bit 7 and sets bit 3.
- R4: While `op_kind` is 2'b01 (program), each read returns status (`rd_array`=0), inverts bit 6 and leaves bit 2 unchanged.
- R5: While `op_kind` is 2'b10 (chip erase) or 2'b11 (sector erase) and `suspended` is 0, each read returns status and inverts both bit 6 and bit 2.
- R6: During an erase with `suspended`=1 and `sect_erasing`=1, a read returns status, inverts bit 2 and leaves bit 6 unchanged.
- R7: During an erase with `suspended`=1 and `sect_erasing`=0, a read gives `rd_array`=1 and `rd_data`=0x00, and it leaves the status byte unchanged.
- R8: `window_expire` sets bit 3 and `suspend_evt` clears it.
- R9: `done` inverts bit 7 and clears bit 3. With `op_kind` 2'b00 (idle) a read gives `rd_array`=1 and leaves the status byte unchanged.
- R10: Bits 5, 4, 1 and 0 of `rd_data` are always 0.
- R11: `rd_data` and `rd_array` change only in the cycle after a read strobe. They carry the status as updated by events and toggles in the strobe cycle, and they hold between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 00 idle, 01 program, 10 chip erase, 11 sector erase |
| suspended | input | 1 | Erase is suspended |
| sect_erasing | input | 1 | Addressed sector is marked for erase |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| prog_data | input | 8 | Data byte being programmed |
| prog_start | input | 1 | Program begins |
| erase_start | input | 1 | Chip or sector erase begins |
| window_expire | input | 1 | Sector-erase accept window closed, erase proper begins |
| suspend_evt | input | 1 | Erase suspend taken |
| resume_evt | input | 1 | Erase resumed |
| done | input | 1 | Operation complete |
| rd_data | output | 8 | Registered status byte returned by the last read |
| rd_array | output | 1 | Last read should return array data instead |

## Verification
Event pulses and read strobes are registered once, so a read's result is due one cycle after its strobe. The bench drives inputs on the falling edge and reads outputs on the following falling edge, after exactly one rising edge. Status changes made by events alone show up only through the next read, so each event is followed by a read, and the bench compares that read against its own running status value. It also confirms that the outputs hold through idle cycles.

// File: rtl/flash_poll_status.sv
module flash_poll_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_kind,
  input  logic       suspended,
  input  logic       sect_erasing,
  input  logic       rd_stb,
  input  logic [7:0] prog_data,
  input  logic       prog_start,
  input  logic       erase_start,
  input  logic       window_expire,
  input  logic       suspend_evt,
  input  logic       resume_evt,
  input  logic       done,
  output logic [7:0] rd_data,
  output logic       rd_array
);

  localparam int B_POLL = 7;
  localparam int B_TGL  = 6;
  localparam int B_WIN  = 3;
  localparam int B_ALT  = 2;

  logic [7:0] stat_q, stat_d;
  logic       busy, is_erase, held, show;

  assign busy     = op_kind != 2'b00;
  assign is_erase = op_kind[1];
  assign held     = is_erase & suspended;
  assign show     = busy & (~held | sect_erasing);

  always_comb begin
    stat_d = stat_q;
    if (prog_start) stat_d[B_POLL] = ~prog_data[7];
    if (erase_start) begin
      stat_d[B_POLL] = 1'b0;
      stat_d[B_WIN]  = 1'b0;
    end
    if (window_expire) stat_d[B_WIN] = 1'b1;
    if (resume_evt) begin
      stat_d[B_POLL] = 1'b0;
      stat_d[B_WIN]  = 1'b1;
    end
    if (suspend_evt) stat_d[B_WIN] = 1'b0;
    if (done) begin
      stat_d[B_POLL] = ~stat_q[B_POLL];
      stat_d[B_WIN]  = 1'b0;
    end
    if (rd_stb && show) begin
      if (!held)   stat_d[B_TGL] = ~stat_d[B_TGL];
      if (is_erase) stat_d[B_ALT] = ~stat_d[B_ALT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= 8'h00;
      rd_data  <= 8'h00;
      rd_array <= 1'b1;
    end else begin
      stat_q <= stat_d;
      if (rd_stb) begin
        rd_data  <= show ? stat_d : 8'h00;
        rd_array <= ~show;
      end
    end
  end

  logic any_evt;
  assign any_evt = prog_start | erase_start | window_expire | suspend_evt | resume_evt | done;

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 8'h33) == 8'h00); // R10

  AST_PROG_TGL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && op_kind == 2'b01 && !any_evt |=>
      stat_q[B_TGL] != $past(stat_q[B_TGL]) && stat_q[B_ALT] == $past(stat_q[B_ALT]) && !rd_array); // R4

  AST_ERASE_TGL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && op_kind[1] && !suspended && !any_evt |=>
      stat_q[B_TGL] != $past(stat_q[B_TGL]) && stat_q[B_ALT] != $past(stat_q[B_ALT])); // R5

  AST_SUSP_HOLD6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && op_kind[1] && suspended && sect_erasing && !any_evt |=>
      $stable(stat_q[B_TGL]) && stat_q[B_ALT] != $past(stat_q[B_ALT]) && !rd_array); // R6

  AST_SUSP_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && op_kind[1] && suspended && !sect_erasing && !any_evt |=>
      rd_array && $stable(stat_q)); // R7

  AST_WIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    window_expire && !done && !suspend_evt |=> stat_q[B_WIN]); // R8

  AST_DONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat_q[B_POLL] != $past(stat_q[B_POLL]) && !stat_q[B_WIN]); // R9

  AST_ERASE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start && !done && !window_expire && !resume_evt |=> !stat_q[B_POLL] && !stat_q[B_WIN]); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data) && $stable(rd_array)); // R11

endmodule

// File: tb/flash_poll_status_tb.sv
module flash_poll_status_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] op_kind = 0;
  logic suspended = 0, sect_erasing = 0, rd_stb = 0;
  logic [7:0] prog_data = 0;
  logic prog_start = 0, erase_start = 0, window_expire = 0;
  logic suspend_evt = 0, resume_evt = 0, done = 0;
  logic [7:0] rd_data;
  logic rd_array;

  int total = 0, bad = 0;
  logic [7:0] m_stat = 8'h00;

  always #(CLK_NS/2) clk = ~clk;

  flash_poll_status u_dut (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .suspended(suspended),
    .sect_erasing(sect_erasing), .rd_stb(rd_stb), .prog_data(prog_data),
    .prog_start(prog_start), .erase_start(erase_start), .window_expire(window_expire),
    .suspend_evt(suspend_evt), .resume_evt(resume_evt), .done(done),
    .rd_data(rd_data), .rd_array(rd_array)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: apply event to model, strobe a read, check result the next falling edge.
  task automatic cyc(input string req, input int ev, input logic [7:0] pd);
    logic [7:0] e_data;
    logic e_arr, held, show;
    prog_start = (ev == 1); erase_start = (ev == 2); window_expire = (ev == 3);
    suspend_evt = (ev == 4); resume_evt = (ev == 5); done = (ev == 6);
    prog_data = pd; rd_stb = 1;
    case (ev)
      1: m_stat[7] = ~pd[7];
      2: begin m_stat[7] = 0; m_stat[3] = 0; end
      3: m_stat[3] = 1;
      4: m_stat[3] = 0;
      5: begin m_stat[7] = 0; m_stat[3] = 1; end
      6: begin m_stat[7] = ~m_stat[7]; m_stat[3] = 0; end
      default: ;
    endcase
    held = op_kind[1] && suspended;
    show = (op_kind != 0) && (!held || sect_erasing);
    if (show) begin
      if (!held) m_stat[6] = ~m_stat[6];
      if (op_kind[1]) m_stat[2] = ~m_stat[2];
    end
    e_data = show ? m_stat : 8'h00;
    e_arr = !show;
    @(posedge clk);
    @(negedge clk);
    {prog_start, erase_start, window_expire, suspend_evt, resume_evt, done, rd_stb} = '0;
    chk(req, {rd_array, rd_data}, {e_arr, e_data});
    chk("R10", {1'b0, rd_data & 8'h33}, 9'h0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {rd_array, rd_data}, 9'h100);

    // R2 R4: program with both polarities of bit 7
    for (int p = 0; p < 2; p++) begin
      op_kind = 2'b01;
      cyc("R2", 1, p ? 8'h80 : 8'h3C);
      cyc("R4", 0, 8'h00);
      cyc("R4", 0, 8'h00);
      cyc("R9", 6, 8'h00);
      op_kind = 2'b00;
      cyc("R9", 0, 8'h00);
    end

    // Sweep both erase kinds with suspend and sector-hit combinations
    for (int k = 2; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        for (int h = 0; h < 2; h++) begin
          op_kind = k[1:0]; suspended = 0; sect_erasing = h[0];
          cyc("R3", 2, 8'h00);
          cyc("R5", 0, 8'h00);
          cyc("R8", 3, 8'h00);
          cyc("R5", 0, 8'h00);
          if (s) begin
            cyc("R8", 4, 8'h00);
            suspended = 1;
            cyc(h ? "R6" : "R7", 0, 8'h00);
            cyc(h ? "R6" : "R7", 0, 8'h00);
            suspended = 0;
            cyc("R3", 5, 8'h00);
            cyc("R5", 0, 8'h00);
          end
          cyc("R9", 6, 8'h00);
          op_kind = 2'b00; sect_erasing = 0;
          cyc("R9", 0, 8'h00);
        end
      end
    end

    // R11: outputs hold while no read strobe, event-only cycles show on next read
    op_kind = 2'b01;
    cyc("R11", 0, 8'h00);
    snap = {rd_array, rd_data};
    prog_start = 1; prog_data = 8'h00; m_stat[7] = 1;
    @(posedge clk); @(negedge clk);
    prog_start = 0;
    repeat (3) @(negedge clk);
    chk("R11", {rd_array, rd_data}, snap);
    cyc("R11", 0, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule